// File: doc/BRIEF.md
# Bus Presence Tracker

The block keeps a table of the device identifiers seen on a single-wire bus and turns the raw stream of search results into clean arrival and departure events. A bus scanner hands it one 64-bit identifier per completed search pass, with a flag that says whether the checksum matched. It also gives a strobe at the start of every scan cycle and a level that says whether the bus is currently shorted. Each identifier is screened, looked up, and either inserted or used to refresh its entry. Every unshorted scan-cycle start ages all entries by one.

Debouncing works in both directions. A new identifier first enters the table as a tentative entry and produces no event. It is reported as an arrival only when it is seen again before it ages out, which in practice means in the next scan cycle. A confirmed entry is refreshed on each sighting, up to a saturation limit `N_LIMIT`. It is reported as departed only after that many scan cycles in a row without a sighting. While the bus is shorted, aging is suspended, so a long short cannot empty the table.

Events leave one per clock through a valid/ready port that carries the identifier. Aging visits the slots one per clock. The block stops taking input while an event waits or an aging walk is in progress.

Top module: `presence_tracker`

## Requirements
- R1: An identifier whose low byte (family code, `id_i[7:0]`) is zero, or that arrives with `crc_ok_i` low, is discarded and leaves the table unchanged.
- R2: A valid identifier that is not in the table is written into the lowest-numbered free slot with age 3 and marked tentative, and no event is produced.
- R3: A sighting of a tentative entry adds 2 to its age. If the result exceeds 3, the entry becomes confirmed with age `N_LIMIT`, and an arrival event (`evt_arrive_o`=1) carrying the identifier is valid in the cycle after the sighting is accepted.
- R4: A sighting of a confirmed entry adds 1 to its age, saturating at `N_LIMIT`, so a confirmed device departs exactly `N_LIMIT` unshorted scan cycles after its last sighting.
- R5: An accepted `cycle_start_i` with `bus_short_i` low decrements the age of every used slot, visiting slots in ascending order, one per clock. `ready_o` stays low for DEPTH cycles plus one cycle per departure event produced.
- R6: A slot whose age reaches zero is freed. A departure event (`evt_arrive_o`=0) carrying its identifier is produced only if the entry was confirmed.
- R7: An accepted `cycle_start_i` with `bus_short_i` high is consumed without aging any entry, and `ready_o` stays high.
- R8: A valid new identifier that finds every slot in use is dropped, and `overflow_o` is high for exactly the cycle after it is accepted.
- R9: A pending event holds `evt_valid_o`, `evt_arrive_o` and `evt_id_o` stable until `evt_ready_i` is high. While it is held, `ready_o` is low and aging does not advance.
- R10: When `cycle_start_i` and `id_valid_i` are both high in an accepted cycle, only the cycle start is taken and the identifier is not processed.
- R11: After reset the table is empty, `ready_o` is high, and `evt_valid_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Identifier from a finished search pass is offered |
| id_i | input | 64 | Device identifier, family code in bits 7:0 |
| crc_ok_i | input | 1 | Checksum of `id_i` matched |
| cycle_start_i | input | 1 | Start of a new scan cycle |
| bus_short_i | input | 1 | Bus currently held low by a short |
| ready_o | output | 1 | Inputs are taken on this clock edge when offered |
| evt_valid_o | output | 1 | Event pending |
| evt_ready_i | input | 1 | Event consumer accepts |
| evt_arrive_o | output | 1 | 1 = arrival, 0 = departure |
| evt_id_o | output | 64 | Identifier of the event |
| overflow_o | output | 1 | One-cycle pulse: new identifier dropped, table full |

## Verification
Arrival events and the overflow pulse are due in the cycle after the accepting edge. The bench samples both at the falling edge that follows that edge. The busy period after an unshorted cycle start is DEPTH cycles plus one per departure. The bench counts the low cycles of `ready_o` against that figure, which it takes from its own model. Events are compared in order against a queue that a behavioural table model fills when each command is driven, so both the order of departures by slot and the suppression of silent removals are checked.

// File: rtl/presence_tracker_pkg.sv
package presence_tracker_pkg;
  localparam int ID_W  = 64;
  localparam int FAM_W = 8;
  localparam int AGE_W = 7;   // age + tentative flag fill one byte

  typedef struct packed {
    logic             tent;
    logic [AGE_W-1:0] age;   // zero marks a free slot
    logic [ID_W-1:0]  id;
  } entry_t;

  typedef enum logic {ST_IDLE, ST_AGE} state_e;
  typedef enum logic {EVT_DEPART = 1'b0, EVT_ARRIVE = 1'b1} evt_kind_e;
endpackage

// File: rtl/pt_screen.sv
module pt_screen
  import presence_tracker_pkg::*;
(
  input  logic [FAM_W-1:0] family_i,
  input  logic             crc_ok_i,
  output logic             ok_o
);
  assign ok_o = crc_ok_i && (family_i != '0);
endmodule

// File: rtl/pt_match.sv
module pt_match
  import presence_tracker_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  entry_t [DEPTH-1:0] tbl_i,
  input  logic [ID_W-1:0]    id_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               free_any_o,
  output logic [IDX_W-1:0]   free_idx_o
);
  logic [DEPTH-1:0] used, eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign used[g] = tbl_i[g].age != '0;
    assign eq[g]   = used[g] && (tbl_i[g].id == id_i);
  end

  assign hit_o      = |eq;
  assign free_any_o = ~&used;

  // descending scan: lowest index wins
  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i])   hit_idx_o  = IDX_W'(i);
      if (!used[i]) free_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/presence_tracker.sv
module presence_tracker
  import presence_tracker_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int N_LIMIT = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_valid_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            crc_ok_i,
  input  logic            cycle_start_i,
  input  logic            bus_short_i,
  output logic            ready_o,
  output logic            evt_valid_o,
  input  logic            evt_ready_i,
  output logic            evt_arrive_o,
  output logic [ID_W-1:0] evt_id_o,
  output logic            overflow_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AGE_W-1:0] AGE_N   = AGE_W'(N_LIMIT);
  localparam logic [AGE_W-1:0] AGE_NEW = AGE_W'(3);

  entry_t [DEPTH-1:0] table_q;
  state_e             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               evt_valid_q, ovf_q;
  evt_kind_e          evt_kind_q;
  logic [ID_W-1:0]    evt_id_q;

  logic             id_ok, hit, free_any, arrive, depart;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             take_id, take_cyc;
  entry_t           hit_ent, upd_ent, age_ent, aged_ent, new_ent;
  logic [AGE_W:0]   sum;

  pt_screen u_screen (
    .family_i (id_i[FAM_W-1:0]),
    .crc_ok_i (crc_ok_i),
    .ok_o     (id_ok)
  );

  pt_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
    .tbl_i      (table_q),
    .id_i       (id_i),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .free_any_o (free_any),
    .free_idx_o (free_idx)
  );

  assign ready_o  = (state_q == ST_IDLE) && !evt_valid_q;
  assign take_cyc = ready_o && cycle_start_i;
  assign take_id  = ready_o && id_valid_i && !cycle_start_i;  // cycle start wins

  assign new_ent = '{tent: 1'b1, age: AGE_NEW, id: id_i};

  // refresh of a matched entry
  always_comb begin
    hit_ent = table_q[hit_idx];
    upd_ent = hit_ent;
    arrive  = 1'b0;
    sum     = {1'b0, hit_ent.age} + (AGE_W+1)'(2);
    if (hit_ent.tent) begin
      if (sum > (AGE_W+1)'(3)) begin
        upd_ent.age  = AGE_N;
        upd_ent.tent = 1'b0;
        arrive       = 1'b1;
      end else begin
        upd_ent.age = sum[AGE_W-1:0];
      end
    end else if (hit_ent.age >= AGE_N) begin
      upd_ent.age = AGE_N;
    end else begin
      upd_ent.age = hit_ent.age + 1'b1;
    end
  end

  // aging of the slot under the walk pointer
  always_comb begin
    age_ent  = table_q[idx_q];
    aged_ent = age_ent;
    depart   = 1'b0;
    if (age_ent.age != '0) begin
      aged_ent.age = age_ent.age - 1'b1;
      if (aged_ent.age == '0) begin
        aged_ent.tent = 1'b0;
        depart        = !age_ent.tent;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      table_q     <= '0;
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      evt_valid_q <= 1'b0;
      evt_kind_q  <= EVT_DEPART;
      evt_id_q    <= '0;
      ovf_q       <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (evt_valid_q && evt_ready_i) evt_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_cyc) begin
            if (!bus_short_i) begin
              state_q <= ST_AGE;
              idx_q   <= '0;
            end
          end else if (take_id && id_ok) begin
            if (hit) begin
              table_q[hit_idx] <= upd_ent;
              if (arrive) begin
                evt_valid_q <= 1'b1;
                evt_kind_q  <= EVT_ARRIVE;
                evt_id_q    <= hit_ent.id;
              end
            end else if (free_any) begin
              table_q[free_idx] <= new_ent;
            end else begin
              ovf_q <= 1'b1;
            end
          end
        end
        ST_AGE: begin
          if (!evt_valid_q) begin
            table_q[idx_q] <= aged_ent;
            if (depart) begin
              evt_valid_q <= 1'b1;
              evt_kind_q  <= EVT_DEPART;
              evt_id_q    <= age_ent.id;
            end
            if (idx_q == IDX_W'(DEPTH - 1)) state_q <= ST_IDLE;
            else                            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign evt_valid_o  = evt_valid_q;
  assign evt_arrive_o = (evt_kind_q == EVT_ARRIVE);
  assign evt_id_o     = evt_id_q;
  assign overflow_o   = ovf_q;

  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_q && !evt_ready_i) |=> (evt_valid_q && $stable(evt_id_q) && $stable(evt_kind_q))); // R9

  AST_SHORT_NO_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cycle_start_i && bus_short_i) |=> ($stable(table_q) && ready_o)); // R7

  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> !free_any); // R8

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_AGE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      table_q[g].age <= AGE_N); // R4
    AST_TENT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      table_q[g].tent |-> (table_q[g].age <= AGE_NEW)); // R2
  end
endmodule

// File: tb/test_presence_tracker.sv
`timescale 1ns/1ps
module test_presence_tracker;
  localparam int DEPTH = 4;
  localparam int NL    = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_valid_i = 1'b0;
  logic [63:0] id_i = '0;
  logic        crc_ok_i = 1'b0;
  logic        cycle_start_i = 1'b0;
  logic        bus_short_i = 1'b0;
  logic        evt_ready_i = 1'b1;
  logic        ready_o, evt_valid_o, evt_arrive_o, overflow_o;
  logic [63:0] evt_id_o;

  always #2.5 clk = ~clk;

  presence_tracker #(.DEPTH(DEPTH), .N_LIMIT(NL)) i_presence_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .id_valid_i(id_valid_i), .id_i(id_i),
    .crc_ok_i(crc_ok_i), .cycle_start_i(cycle_start_i), .bus_short_i(bus_short_i),
    .ready_o(ready_o), .evt_valid_o(evt_valid_o), .evt_ready_i(evt_ready_i),
    .evt_arrive_o(evt_arrive_o), .evt_id_o(evt_id_o), .overflow_o(overflow_o)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct { bit arr; logic [63:0] id; string tag; } exp_t;
  exp_t q[$];

  // behavioural table model
  logic [63:0] m_id[DEPTH];
  int          m_age[DEPTH];
  bit          m_tent[DEPTH];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_id(input logic [63:0] id, input bit crc, input string tag,
                          output bit arr, output bit ovf);
    int hit, fr;
    arr = 0; ovf = 0; hit = -1; fr = -1;
    if (id[7:0] == 8'h00 || !crc) return;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_age[i] != 0 && m_id[i] == id && hit < 0) hit = i;
      if (m_age[i] == 0 && fr < 0) fr = i;
    end
    if (hit >= 0) begin
      if (m_tent[hit]) begin
        m_age[hit] += 2;
        if (m_age[hit] > 3) begin
          m_age[hit] = NL; m_tent[hit] = 0; arr = 1;
          q.push_back('{1'b1, id, tag});
        end
      end else if (m_age[hit] < NL) m_age[hit]++;
    end else if (fr >= 0) begin
      m_id[fr] = id; m_age[fr] = 3; m_tent[fr] = 1;
    end else ovf = 1;
  endtask

  function automatic int model_cycle(input bit short, input string tag);
    int deps = 0;
    if (short) return 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_age[i] != 0) begin
        m_age[i]--;
        if (m_age[i] == 0) begin
          if (!m_tent[i]) begin deps++; q.push_back('{1'b0, m_id[i], tag}); end
          m_tent[i] = 0;
        end
      end
    end
    return deps;
  endfunction

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  task automatic send_id(input logic [63:0] id, input bit crc, input string tag);
    bit ea, eo;
    wait_ready();
    id_i = id; crc_ok_i = crc; id_valid_i = 1'b1;
    model_id(id, crc, tag, ea, eo);
    @(negedge clk);
    id_valid_i = 1'b0;
    check(overflow_o == eo, tag, "overflow_o", 64'(overflow_o), 64'(eo));
    check(evt_valid_o == ea, tag, "arrival due", 64'(evt_valid_o), 64'(ea));
  endtask

  task automatic send_cycle(input bit short, input string tag, input bit timed);
    int deps, busy;
    wait_ready();
    cycle_start_i = 1'b1; bus_short_i = short;
    deps = model_cycle(short, tag);
    @(negedge clk);
    cycle_start_i = 1'b0; bus_short_i = 1'b0;
    if (timed) begin
      busy = 0;
      while (!ready_o) begin busy++; @(negedge clk); end
      check(busy == (short ? 0 : DEPTH + deps), tag, "busy cycles",
            64'(busy), 64'(short ? 0 : DEPTH + deps));
    end
  endtask

  task automatic send_both(input logic [63:0] id, input string tag);
    int deps;
    wait_ready();
    id_i = id; crc_ok_i = 1'b1; id_valid_i = 1'b1; cycle_start_i = 1'b1;
    deps = model_cycle(1'b0, tag);
    @(negedge clk);
    id_valid_i = 1'b0; cycle_start_i = 1'b0;
    wait_ready();
  endtask

  // event monitor
  always @(negedge clk) begin
    if (rst_ni && evt_valid_o && evt_ready_i) begin
      if (q.size() == 0) begin
        total++; fails++;
        $display("FAIL R6 unexpected event: actual %h expected none", evt_id_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(evt_arrive_o == e.arr, e.tag, "event kind", 64'(evt_arrive_o), 64'(e.arr));
        check(evt_id_o == e.id, e.tag, "event id", evt_id_o, e.id);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 40000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  localparam logic [63:0] ID_A = 64'hA1A2_A3A4_A5A6_A7A1;
  localparam logic [63:0] ID_B = 64'hB1B2_B3B4_B5B6_B7B2;
  localparam logic [63:0] ID_C = 64'hC1C2_C3C4_C5C6_C7C3;
  localparam logic [63:0] ID_D = 64'hD1D2_D3D4_D5D6_D7D4;
  localparam logic [63:0] ID_X = 64'h0102_0304_0506_0728;
  localparam logic [63:0] ID_Z = 64'h5555_6666_7777_8800;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_id[i] = '0; m_age[i] = 0; m_tent[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1, "R11", "ready_o", 64'(ready_o), 64'd1);
    check(evt_valid_o == 1'b0, "R11", "evt_valid_o", 64'(evt_valid_o), 64'd0);
    check(overflow_o == 1'b0, "R11", "overflow_o", 64'(overflow_o), 64'd0);

    // R1: zero family and bad checksum are discarded
    send_id(ID_Z, 1'b1, "R1");
    send_id(ID_X, 1'b0, "R1");
    send_cycle(1'b0, "R5", 1'b1);
    send_id(ID_Z, 1'b1, "R1");
    send_id(ID_X, 1'b1, "R1");          // fresh insert, no arrival

    // R2/R3: tentative then confirmed in next cycle
    send_id(ID_A, 1'b1, "R2");
    send_cycle(1'b0, "R5", 1'b1);
    send_id(ID_A, 1'b1, "R3");

    // R4: saturation, departure after exactly NL misses; R6 silent removal of X
    repeat (3) send_id(ID_A, 1'b1, "R4");
    repeat (NL) send_cycle(1'b0, "R4", 1'b1);

    // R7: shorted cycles do not age
    send_id(ID_B, 1'b1, "R2");
    send_cycle(1'b0, "R5", 1'b1);
    send_id(ID_B, 1'b1, "R3");
    repeat (3) send_cycle(1'b1, "R7", 1'b1);
    repeat (NL) send_cycle(1'b0, "R6", 1'b1);

    // R3: two sightings within one cycle confirm
    send_id(ID_C, 1'b1, "R2");
    send_id(ID_C, 1'b1, "R3");

    // R10: cycle start wins over a simultaneous identifier
    send_both(ID_D, "R10");
    send_id(ID_D, 1'b1, "R10");

    // R9: departure held under backpressure
    repeat (NL - 2) send_cycle(1'b0, "R6", 1'b1);
    @(posedge clk); #1 evt_ready_i = 1'b0;
    @(negedge clk);
    send_cycle(1'b0, "R9", 1'b0);
    repeat (6) @(negedge clk);
    check(evt_valid_o == 1'b1, "R9", "held evt_valid_o", 64'(evt_valid_o), 64'd1);
    check(ready_o == 1'b0, "R9", "ready_o while held", 64'(ready_o), 64'd0);
    check(q.size() != 0 && evt_id_o == q[0].id, "R9", "held evt_id_o", evt_id_o,
          (q.size() != 0) ? q[0].id : 64'd0);
    @(posedge clk); #1 evt_ready_i = 1'b1;
    @(negedge clk);
    wait_ready();
    repeat (NL + 1) send_cycle(1'b0, "R6", 1'b1);

    // R8: overflow when full, then room again after tentatives expire
    for (int k = 0; k < DEPTH; k++) send_id(64'h4000_0000_0000_0011 + 64'(k << 8), 1'b1, "R2");
    send_id(64'h4000_0000_0000_00F1, 1'b1, "R8");
    repeat (3) send_cycle(1'b0, "R6", 1'b1);
    send_id(64'h4000_0000_0000_00F1, 1'b1, "R8");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6", "events outstanding", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule